// File: doc/BRIEF.md
# Oversampled Bit Recovery with Majority Filter

This block takes an asynchronous binary receive line and recovers a clean bit stream with its bit clock. It runs from a 76.8 kHz reference clock and makes a sample strobe at sixteen times the selected bit rate. The 512 bit/s rate does not divide the reference evenly, so all rates share one fractional accumulator. The line passes a two-stage synchronizer and an optional polarity inversion. It is then sampled on each strobe. A majority vote over the last sixteen samples decides each bit.

A phase counter splits each bit period into 32 sub-steps. Every sample advances it by two. When the sampled line changes level, the counter is pulled toward that transition. The block makes at most one such correction per bit. The size of the correction comes from `lock_i`, which the downstream synchronization logic drives. While `lock_i` is low the step is coarse (1/8 bit), and once a valid preamble or sync sequence has been seen the step is fine (1/32 bit). Each finished bit is presented on `bit_o` with a one-cycle `bit_valid_o` strobe.

Top module: `rx_bit_recovery`

## Requirements
- R1: `rate_sel_i` selects the bit rate: code 0 is 512 bit/s, code 1 is 1200 bit/s, and codes 2 and 3 are 2400 bit/s. The sample strobe runs at 16 times that rate, derived from the reference clock by fractional accumulation. With a steady line and no corrections, `bit_valid_o` pulses every 150, 64 or 32 clocks respectively.
- R2: With `invert_i` high the synchronized line is inverted before sampling. A steady high input then yields `bit_o` = 0, and with `invert_i` low it yields 1.
- R3: Each bit is decided over the 16 most recent samples, ending with the sample that closes the bit. The result is 1 when at least 9 of them are 1. A one-clock glitch once per bit never changes a steady bit value.
- R4: `bit_valid_o` is high for exactly one clock per bit, and `bit_o` changes only in a cycle where `bit_valid_o` is high.
- R5: The phase counter holds 32 sub-steps per bit and advances 2 per sample. A sample that differs from the previous one is a transition. At phase 1..15 the transition retards the phase by one step, at phase 16..31 it advances the phase by one step, and at phase 0 it causes no correction. No bit receives more than one correction.
- R6: While `lock_i` is low the correction step is 4 sub-steps. At 2400 bit/s, bit intervals are then 28, 32 or 36 clocks.
- R7: While `lock_i` is high the correction step is 1 sub-step. At 2400 bit/s, intervals are then 30, 32 or 34 clocks, and the loop tracks a transmitter whose bit period is 33 clocks.
- R8: During and right after reset, `bit_o` and `bit_valid_o` are 0, the phase is 0 and the sample history is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 76.8 kHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Asynchronous receive line |
| invert_i | input | 1 | Invert line polarity before sampling |
| rate_sel_i | input | 2 | Bit-rate code (0: 512, 1: 1200, 2/3: 2400 bit/s) |
| lock_i | input | 1 | High selects the fine phase-correction step |
| bit_o | output | 1 | Last recovered bit |
| bit_valid_o | output | 1 | One-cycle strobe for a new recovered bit |

## Verification
A level on `data_i` reaches the sampling logic after two synchronizer clocks. A sample strobe is registered one clock after the accumulator wraps. `bit_o` and `bit_valid_o` update one clock after the strobe that closes a bit. The bench reference model steps through these same delays clock by clock from the input ports and compares both outputs at every falling edge, so each result is checked in exactly the cycle it becomes due. Rate, step-size and glitch checks measure the clock spacing between `bit_valid_o` strobes, or the bits they carry. These checks skip the first few strobes after any rate, polarity or lock change.

// File: rtl/rxbr_pkg.sv
package rxbr_pkg;
  localparam int REF_HZ_DEF  = 76800;
  localparam int RATE_LO_HZ  = 512;
  localparam int RATE_MID_HZ = 1200;
  localparam int RATE_HI_HZ  = 2400;

  typedef enum logic [1:0] {
    RATE_LO     = 2'd0,
    RATE_MID    = 2'd1,
    RATE_HI     = 2'd2,
    RATE_HI_ALT = 2'd3
  } rate_e;
endpackage

// File: rtl/rxbr_tick_gen.sv
module rxbr_tick_gen
  import rxbr_pkg::*;
#(
  parameter int REF_HZ = REF_HZ_DEF,
  parameter int OSR    = 16,
  parameter int LO_HZ  = RATE_LO_HZ,
  parameter int MID_HZ = RATE_MID_HZ,
  parameter int HI_HZ  = RATE_HI_HZ
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  output logic       tick_o
);
  localparam int ACC_W = $clog2(REF_HZ);
  localparam logic [ACC_W:0] REF_W  = (ACC_W+1)'(REF_HZ);
  localparam logic [ACC_W:0] INC_LO = (ACC_W+1)'(OSR*LO_HZ);
  localparam logic [ACC_W:0] INC_MI = (ACC_W+1)'(OSR*MID_HZ);
  localparam logic [ACC_W:0] INC_HI = (ACC_W+1)'(OSR*HI_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   inc, sum;
  logic             wrap;

  always_comb begin
    case (rate_e'(rate_sel_i))
      RATE_LO:  inc = INC_LO;
      RATE_MID: inc = INC_MI;
      default:  inc = INC_HI;
    endcase
    sum  = {1'b0, acc_q} + inc;
    wrap = (sum >= REF_W);
  end

  // fractional divide: strobe on every wrap of the phase accumulator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= wrap ? ACC_W'(sum - REF_W) : sum[ACC_W-1:0];
      tick_o <= wrap;
    end
  end
endmodule

// File: rtl/rxbr_line_cond.sv
module rxbr_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic invert_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], data_i};
  end

  assign line_o = sync_q[STAGES-1] ^ invert_i;
endmodule

// File: rtl/rxbr_phase_track.sv
module rxbr_phase_track #(
  parameter int OSR      = 16,
  parameter int SUBSTEPS = 32,
  parameter int MAJ_MIN  = 9,
  parameter int COARSE   = 4,
  parameter int FINE     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic lock_i,
  output logic bit_o,
  output logic bit_valid_o
);
  localparam int PH_W = $clog2(SUBSTEPS);
  localparam int ADV  = SUBSTEPS / OSR;
  localparam logic [PH_W-1:0] HALF = PH_W'(SUBSTEPS / 2);

  logic [PH_W-1:0] phase_q;
  logic [OSR-1:0]  win_q, win_n;
  logic            prev_q, done_q;
  logic            do_corr, wrap, majority;
  int              step, ph_sum;

  always_comb begin
    win_n    = {win_q[OSR-2:0], line_i};
    majority = ($countones(win_n) >= MAJ_MIN);
    step     = lock_i ? FINE : COARSE;
    do_corr  = (line_i != prev_q) && !done_q && (phase_q != '0);
    ph_sum   = int'(phase_q) + ADV;
    // early half: our boundary ran ahead, hold back; late half: catch up
    if (do_corr) ph_sum = (phase_q < HALF) ? ph_sum - step : ph_sum + step;
    if (ph_sum < 0) ph_sum = 0;
    wrap = (ph_sum >= SUBSTEPS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= '0;
      win_q       <= '0;
      prev_q      <= 1'b0;
      done_q      <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else if (tick_i) begin
      prev_q <= line_i;
      win_q  <= win_n;
      if (wrap) begin
        phase_q     <= PH_W'(ph_sum - SUBSTEPS);
        bit_o       <= majority;
        bit_valid_o <= 1'b1;
        done_q      <= 1'b0;
      end else begin
        phase_q     <= PH_W'(ph_sum);
        bit_valid_o <= 1'b0;
        done_q      <= done_q | do_corr;
      end
    end else begin
      bit_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_bit_recovery.sv
module rx_bit_recovery
  import rxbr_pkg::*;
#(
  parameter int REF_HZ      = REF_HZ_DEF,
  parameter int OSR         = 16,
  parameter int SUBSTEPS    = 32,
  parameter int MAJ_MIN     = 9,
  parameter int COARSE      = 4,
  parameter int FINE        = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_i,
  input  logic       invert_i,
  input  logic [1:0] rate_sel_i,
  input  logic       lock_i,
  output logic       bit_o,
  output logic       bit_valid_o
);
  logic tick;
  logic line;

  rxbr_tick_gen #(
    .REF_HZ (REF_HZ),
    .OSR    (OSR),
    .LO_HZ  (RATE_LO_HZ),
    .MID_HZ (RATE_MID_HZ),
    .HI_HZ  (RATE_HI_HZ)
  ) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick)
  );

  rxbr_line_cond #(
    .STAGES (SYNC_STAGES)
  ) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .invert_i (invert_i),
    .line_o   (line)
  );

  rxbr_phase_track #(
    .OSR      (OSR),
    .SUBSTEPS (SUBSTEPS),
    .MAJ_MIN  (MAJ_MIN),
    .COARSE   (COARSE),
    .FINE     (FINE)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .line_i      (line),
    .lock_i      (lock_i),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o)
  );
endmodule

// File: rtl/rxbr_checker.sv
module rxbr_checker #(
  parameter int MIN_TICKS = 12  // 32 sub-steps from worst remainder 5 with one +4 step
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic bit_o,
  input logic bit_valid_o
);
  logic [7:0] tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tick_cnt <= '0;
    else if (bit_valid_o)                 tick_cnt <= tick_i ? 8'd1 : 8'd0;
    else if (tick_i && tick_cnt != 8'hFF) tick_cnt <= tick_cnt + 8'd1;
  end

  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  a_r4_bit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_o) |-> bit_valid_o);

  a_r1_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  a_r5_min_bit_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (tick_cnt >= 8'(MIN_TICKS)));
endmodule

bind rx_bit_recovery rxbr_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o)
);

// File: tb/sim_rx_bit_recovery.sv
module sim_rx_bit_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0, data = 1'b0, inv = 1'b0, lock = 1'b0;
  logic [1:0] rate = 2'd2;
  logic       bit_w, valid_w;

  rx_bit_recovery u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .invert_i(inv),
    .rate_sel_i(rate), .lock_i(lock), .bit_o(bit_w), .bit_valid_o(valid_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, failures = 0, cyc = 0;
  string cur_req = "R8";
  bit    done_flag = 1'b0;

  // behavioural reference state
  logic m_s1, m_s2, m_tick, m_prev, m_done, e_valid, e_bit;
  int   m_acc, m_phase;
  int   win[$];

  function automatic int rate_hz(logic [1:0] r);
    case (r)
      2'd0:    return 512;
      2'd1:    return 1200;
      default: return 2400;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_tick = 0; m_prev = 0; m_done = 0;
      e_valid = 0; e_bit = 0; m_acc = 0; m_phase = 0;
      win.delete();
      for (int i = 0; i < 16; i++) win.push_back(0);
    end else begin
      logic smp, t;
      int   nacc, adj, np, ones;
      smp  = m_s2 ^ inv;
      t    = m_tick;
      nacc = m_acc + 16 * rate_hz(rate);
      if (nacc >= 76800) begin m_acc = nacc - 76800; m_tick = 1; end
      else begin m_acc = nacc; m_tick = 0; end
      m_s2 = m_s1;
      m_s1 = data;
      if (t) begin
        void'(win.pop_front());
        win.push_back(int'(smp));
        adj = 0;
        if (smp != m_prev && !m_done && m_phase != 0)
          adj = (m_phase < 16) ? -(lock ? 1 : 4) : (lock ? 1 : 4);
        m_prev = smp;
        np = m_phase + 2 + adj;
        if (np < 0) np = 0;
        if (np >= 32) begin
          ones = 0;
          foreach (win[i]) ones += win[i];
          m_phase = np - 32;
          e_valid = 1;
          e_bit   = (ones >= 9);
          m_done  = 0;
        end else begin
          m_phase = np;
          e_valid = 0;
          if (adj != 0) m_done = 1;
        end
      end else begin
        e_valid = 0;
      end
    end
  end

  int ivals[$];
  int vbits[$];
  bit have_last = 0, prev_valid = 0;
  int last_cyc = 0;

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // per-clock comparison and strobe monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done_flag) begin
      checks++;
      if (valid_w !== e_valid || bit_w !== e_bit) begin
        failures++;
        $display("FAIL %s cycle %0d: valid=%b bit=%b expected valid=%b bit=%b",
                 cur_req, cyc, valid_w, bit_w, e_valid, e_bit);
      end
      if (valid_w === 1'b1) begin
        checks++;
        if (prev_valid) begin
          failures++;
          $display("FAIL R4 cycle %0d: strobe width 2+ expected 1", cyc);
        end
        if (have_last) ivals.push_back(cyc - last_cyc);
        last_cyc  = cyc;
        have_last = 1;
        vbits.push_back(int'(bit_w));
      end
      prev_valid = (valid_w === 1'b1);
    end
    if (cyc > WATCHDOG && !done_flag) begin
      failures++;
      $display("FAIL watchdog: cycle %0d expected finish before %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ivals.delete();
    vbits.delete();
    have_last = 0;
  endtask

  task automatic send(int nbits, int period, int kind, bit glitch);
    logic [7:0] lfsr = 8'hA5;
    for (int b = 0; b < nbits; b++) begin
      logic v;
      case (kind)
        0:       v = 1'b0;
        1:       v = 1'b1;
        2:       v = b[0];
        default: begin
          v    = lfsr[0];
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
      endcase
      for (int c = 0; c < period; c++) begin
        @(negedge clk);
        data = (glitch && c == period / 3) ? ~v : v;
      end
    end
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    // R8: reset values
    check(valid_w === 1'b0, "R8", "bit_valid_o after reset", int'(valid_w), 0);
    check(bit_w === 1'b0, "R8", "bit_o after reset", int'(bit_w), 0);

    // R1: strobe spacing per rate code, steady line
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin
      int code, per;
      code = (k == 0) ? 2 : (k == 1) ? 1 : (k == 2) ? 0 : 3;
      per  = (code == 0) ? 150 : (code == 1) ? 64 : 32;
      rate = 2'(code);
      clear_mon();
      send(20, per, 0, 0);
      for (int i = 3; i < ivals.size(); i++)
        check(ivals[i] == per, "R1", "bit interval", ivals[i], per);
    end

    // R2: polarity inversion
    cur_req = "R2";
    rate = 2'd2;
    inv  = 1'b0;
    send(10, 32, 1, 0);
    check(bit_w === 1'b1, "R2", "steady high, no invert", int'(bit_w), 1);
    inv = 1'b1;
    send(10, 32, 1, 0);
    check(bit_w === 1'b0, "R2", "steady high, inverted", int'(bit_w), 0);
    inv = 1'b0;

    // R3: majority rejects a one-clock glitch per bit
    cur_req = "R3";
    clear_mon();
    send(20, 32, 1, 1);
    for (int i = 3; i < vbits.size(); i++)
      check(vbits[i] == 1, "R3", "glitched steady high bit", vbits[i], 1);

    // R5, R6: coarse step from a fresh phase with offset transitions
    @(negedge clk); rst_n = 1'b0;
    step(3); rst_n = 1'b1;
    cur_req = "R6";
    lock = 1'b0;
    step(10);
    clear_mon();
    send(40, 32, 2, 0);
    begin
      int moved = 0;
      foreach (ivals[i]) begin
        check(ivals[i] == 28 || ivals[i] == 32 || ivals[i] == 36, "R5",
              "coarse interval in {28,32,36}", ivals[i], 32);
        if (ivals[i] != 32) moved++;
      end
      check(moved > 0, "R6", "coarse corrections seen", moved, 1);
    end

    // R7: fine step tracking a 33-clock transmitter
    cur_req = "R7";
    lock = 1'b1;
    clear_mon();
    send(40, 33, 2, 0);
    begin
      int longer = 0;
      for (int i = 3; i < ivals.size(); i++) begin
        check(ivals[i] == 30 || ivals[i] == 32 || ivals[i] == 34, "R7",
              "fine interval in {30,32,34}", ivals[i], 32);
        if (ivals[i] == 34) longer++;
      end
      check(longer > 0, "R7", "fine tracking of slow transmitter", longer, 1);
    end

    // R3: pseudo-random data, coarse then fine, against the model
    cur_req = "R3";
    rate = 2'd1;
    lock = 1'b0;
    send(30, 64, 3, 0);
    lock = 1'b1;
    send(30, 64, 3, 0);
    step(4);
    finish_run();
  end
endmodule